// File: doc/BRIEF.md
# Configurable Limit Alert Controller

This block watches measurement results from several monitored channels and reduces them to one alert pin. It has a fixed number of independent alert slots. Each slot carries its own channel selector, its own comparison kind and its own 16-bit threshold. When the selected channel publishes fresh results, the slot compares one quantity against its threshold. The quantity is the shunt reading, the bus reading or the power reading. The slot then records whether a fault is present.

Two event sources can also drive the alert pin when their enables are set:
- a conversion-complete event, which is held in a ready flag until the flags are read;
- energy-overflow indications from the channels that are switched on.

All active causes are ORed together. The result is shaped by a polarity control and registered before it reaches the pin. In latched mode, a slot's fault indication survives until the host reads the flags and the fault has also gone away. The host bus interface sits outside this block; it only provides a flags-read strobe.

Top module: `limit_alert_ctrl`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), all slot flags and the ready flag are 0, and `alert_pin` equals the inverse of `alert_pol`.
- R2: A slot compares only on a clock edge where `res_valid` is high for the channel its selector names. The selector is 2 bits wide: 0 picks channel 0 and 3 picks channel 3. Strobes of other channels leave the slot's flag unchanged.
- R3: Kind code 3'b001 flags a fault when the shunt result is greater than the limit. Kind code 3'b010 flags a fault when it is less than the limit. Both comparisons are signed 16-bit, and equality is not a fault.
- R4: Kind code 3'b011 (over) and kind code 3'b100 (under) compare bus results against the limit. Only bits 14:0 of each are used, as unsigned numbers, and bit 15 of both is ignored.
- R5: Kind code 3'b101 flags a fault when the power result is greater than the limit, compared as unsigned 16-bit. Equality is not a fault.
- R6: Kind codes 3'b000, 3'b110 and 3'b111 never raise the slot flag, whatever the data.
- R7: Bit i of `slot_flag` belongs to slot i, whichever channel that slot watches. With `latch_en` low, the flag shows the most recent comparison result of its slot and is visible the cycle after the strobe.
- R8: With `latch_en` high, a raised slot flag holds until a `flags_rd` strobe arrives while that slot's latest comparison is clean. A read during a fault leaves the flag set.
- R9: `cnv_done` sets `ready_flag` on the next edge, and `flags_rd` clears it; a set in the same cycle wins. While `cnv_mask` is high, a set `ready_flag` asserts the alert.
- R10: While `eovf_mask` is high, any bit of `eovf` whose matching `ch_en` bit is high asserts the alert. Overflow from a disabled channel, or any overflow while the mask is low, has no effect.
- R11: `alert_pin` is registered one cycle after its causes. It equals the OR of all causes when `alert_pol` is 1, and the inverse of that OR when `alert_pol` is 0 (active low).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| res_valid | input | NUM_CH | Per-channel strobe: new results present |
| shunt_res | input | NUM_CH*RES_W | Signed shunt results, channel 0 in the low bits |
| bus_res | input | NUM_CH*RES_W | Bus results, channel 0 in the low bits |
| pwr_res | input | NUM_CH*RES_W | Unsigned power results, channel 0 in the low bits |
| slot_chan | input | NUM_SLOT*CH_W | Channel selector of each slot |
| slot_kind | input | NUM_SLOT*3 | Comparison kind code of each slot |
| slot_limit | input | NUM_SLOT*RES_W | Threshold of each slot |
| latch_en | input | 1 | Hold slot faults until read and cleared |
| alert_pol | input | 1 | 1: active-high pin, 0: active-low pin |
| cnv_mask | input | 1 | Route the ready flag to the alert |
| eovf_mask | input | 1 | Route energy overflow to the alert |
| cnv_done | input | 1 | Conversion-complete event pulse |
| eovf | input | NUM_CH | Per-channel energy-overflow indication |
| ch_en | input | NUM_CH | Per-channel enable |
| flags_rd | input | 1 | Host has read the flags |
| alert_pin | output | 1 | Registered alert output |
| slot_flag | output | NUM_SLOT | Per-slot limit fault flags |
| ready_flag | output | 1 | Conversion ready flag |

## Verification
A slot that has lost its fault record, or has set one wrongly, shows at `slot_flag` on the edge after the strobe that should have changed it. It also shows at `alert_pin` one edge later. A latch that forgets its fault shows up before any read, because the flag drops on a clean comparison. A ready flag that is stuck, or an event path with the wrong mask, shows at the pin within two edges of its pulse or level change. Polarity errors show on the very first cycle after reset.

// File: rtl/lac_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the limit alert controller.
// Assumes a 3-bit comparison kind code per alert slot.
package lac_pkg;

    localparam int KIND_W = 3;

    // Comparison kind codes; the code values are part of the slot configuration.
    typedef enum logic [KIND_W-1:0] {
        KIND_NONE      = 3'b000,
        KIND_SH_OVER   = 3'b001,
        KIND_SH_UNDER  = 3'b010,
        KIND_BUS_OVER  = 3'b011,
        KIND_BUS_UNDER = 3'b100,
        KIND_PWR_OVER  = 3'b101,
        KIND_RSV_A     = 3'b110,
        KIND_RSV_B     = 3'b111
    } lim_kind_e;

endpackage

// File: rtl/lac_slot.sv
`timescale 1ns/1ps
// One alert slot: picks the results of its selected channel, compares one
// quantity against the slot limit on that channel's strobe, and keeps a
// fault record and a (optionally latched) flag.
// Assumes: results are stable while res_valid is high; the limit uses the
// format of the compared result (signed shunt, 15-bit bus, unsigned power).
module lac_slot #(
    parameter int NUM_CH = 4,
    parameter int RES_W  = 16,
    parameter int CH_W   = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_CH-1:0]       res_valid,
    input  logic [NUM_CH*RES_W-1:0] shunt_all,
    input  logic [NUM_CH*RES_W-1:0] bus_all,
    input  logic [NUM_CH*RES_W-1:0] pwr_all,
    input  logic [CH_W-1:0]         chan_sel,
    input  logic [2:0]              kind,
    input  logic [RES_W-1:0]        limit,
    input  logic                    latch_en,
    input  logic                    flags_rd,
    output logic                    flag
);
    import lac_pkg::*;

    localparam int MAG_W = RES_W - 1;

    logic [RES_W-1:0] sh_v;
    logic [MAG_W-1:0] bus_v;
    logic [RES_W-1:0] pwr_v;
    logic             strobe_hit;
    logic             cmp_fault;
    logic             fault_q;
    logic             fault_nxt;
    logic             flag_q;

    // Route the selected channel's results and strobe to this slot.
    always_comb begin
        sh_v       = '0;
        bus_v      = '0;
        pwr_v      = '0;
        strobe_hit = 1'b0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (chan_sel == CH_W'(c)) begin
                sh_v       = shunt_all[c*RES_W +: RES_W];
                bus_v      = bus_all[c*RES_W +: MAG_W];
                pwr_v      = pwr_all[c*RES_W +: RES_W];
                strobe_hit = res_valid[c];
            end
        end
    end

    // Compare the chosen quantity with the limit in that quantity's format.
    always_comb begin
        case (lim_kind_e'(kind))
            KIND_SH_OVER:   cmp_fault = $signed(sh_v) > $signed(limit);
            KIND_SH_UNDER:  cmp_fault = $signed(sh_v) < $signed(limit);
            KIND_BUS_OVER:  cmp_fault = bus_v > limit[MAG_W-1:0];
            KIND_BUS_UNDER: cmp_fault = bus_v < limit[MAG_W-1:0];
            KIND_PWR_OVER:  cmp_fault = pwr_v > limit;
            default:        cmp_fault = 1'b0;
        endcase
    end

    // Next fault record: the new result on a strobe, otherwise the old one.
    assign fault_nxt = strobe_hit ? cmp_fault : fault_q;

    // Keep the fault record and the visible flag (tracking or latched).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault_q <= 1'b0;
            flag_q  <= 1'b0;
        end else begin
            fault_q <= fault_nxt;
            if (!latch_en) begin
                flag_q <= fault_nxt;
            end else if (strobe_hit && cmp_fault) begin
                flag_q <= 1'b1;
            end else if (flags_rd && !fault_nxt) begin
                flag_q <= 1'b0;
            end
        end
    end

    assign flag = flag_q;

endmodule

// File: rtl/lac_event.sv
`timescale 1ns/1ps
// Event sources for the alert: holds the conversion-ready flag and
// combines it with the energy-overflow indications of enabled channels.
// Assumes cnv_done is a one-cycle pulse and eovf is a level per channel.
module lac_event #(
    parameter int NUM_CH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnv_done,
    input  logic              flags_rd,
    input  logic              cnv_mask,
    input  logic              eovf_mask,
    input  logic [NUM_CH-1:0] eovf,
    input  logic [NUM_CH-1:0] ch_en,
    output logic              ready_flag,
    output logic              evt_active
);
    logic ready_q;

    // Ready flag: set by a conversion event, cleared by a flags read (set wins).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ready_q <= 1'b0;
        end else if (cnv_done) begin
            ready_q <= 1'b1;
        end else if (flags_rd) begin
            ready_q <= 1'b0;
        end
    end

    // Masked event causes that feed the alert.
    assign evt_active = (cnv_mask & ready_q) | (eovf_mask & (|(eovf & ch_en)));
    assign ready_flag = ready_q;

endmodule

// File: rtl/lac_alert_drive.sv
`timescale 1ns/1ps
// Alert pin driver: ORs all slot flags with the event causes, applies the
// polarity and registers the result for one cycle.
// Assumes alert_pol is quasi-static; reset puts the pin at its idle level.
module lac_alert_drive #(
    parameter int NUM_SLOT = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_SLOT-1:0] slot_flag,
    input  logic                evt_active,
    input  logic                alert_pol,
    output logic                alert_pin
);
    logic any_cause;
    logic pin_q;

    // Collapse every cause into one request.
    assign any_cause = (|slot_flag) | evt_active;

    // Register the polarity-shaped request onto the pin.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_q <= ~alert_pol;
        end else begin
            pin_q <= alert_pol ? any_cause : ~any_cause;
        end
    end

    assign alert_pin = pin_q;

endmodule

// File: rtl/limit_alert_ctrl.sv
`timescale 1ns/1ps
// Limit alert controller top: NUM_SLOT independent comparison slots, each
// watching one of NUM_CH channels, plus conversion-ready and energy-overflow
// event paths, all merged onto one polarity-selectable alert pin.
// Assumes: flat buses carry channel/slot 0 in their least significant bits.
module limit_alert_ctrl #(
    parameter int NUM_CH   = 4,
    parameter int NUM_SLOT = 4,
    parameter int RES_W    = 16,
    localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_CH-1:0]         res_valid,
    input  logic [NUM_CH*RES_W-1:0]   shunt_res,
    input  logic [NUM_CH*RES_W-1:0]   bus_res,
    input  logic [NUM_CH*RES_W-1:0]   pwr_res,
    input  logic [NUM_SLOT*CH_W-1:0]  slot_chan,
    input  logic [NUM_SLOT*3-1:0]     slot_kind,
    input  logic [NUM_SLOT*RES_W-1:0] slot_limit,
    input  logic                      latch_en,
    input  logic                      alert_pol,
    input  logic                      cnv_mask,
    input  logic                      eovf_mask,
    input  logic                      cnv_done,
    input  logic [NUM_CH-1:0]         eovf,
    input  logic [NUM_CH-1:0]         ch_en,
    input  logic                      flags_rd,
    output logic                      alert_pin,
    output logic [NUM_SLOT-1:0]       slot_flag,
    output logic                      ready_flag
);
    logic [NUM_SLOT-1:0] flag_w;
    logic                evt_w;

    // One comparison slot per configured alert.
    for (genvar s = 0; s < NUM_SLOT; s++) begin : g_slot
        lac_slot #(
            .NUM_CH (NUM_CH),
            .RES_W  (RES_W),
            .CH_W   (CH_W)
        ) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .res_valid (res_valid),
            .shunt_all (shunt_res),
            .bus_all   (bus_res),
            .pwr_all   (pwr_res),
            .chan_sel  (slot_chan[s*CH_W +: CH_W]),
            .kind      (slot_kind[s*3 +: 3]),
            .limit     (slot_limit[s*RES_W +: RES_W]),
            .latch_en  (latch_en),
            .flags_rd  (flags_rd),
            .flag      (flag_w[s])
        );
    end

    lac_event #(.NUM_CH(NUM_CH)) u_event (
        .clk        (clk),
        .rst_n      (rst_n),
        .cnv_done   (cnv_done),
        .flags_rd   (flags_rd),
        .cnv_mask   (cnv_mask),
        .eovf_mask  (eovf_mask),
        .eovf       (eovf),
        .ch_en      (ch_en),
        .ready_flag (ready_flag),
        .evt_active (evt_w)
    );

    lac_alert_drive #(.NUM_SLOT(NUM_SLOT)) u_drive (
        .clk        (clk),
        .rst_n      (rst_n),
        .slot_flag  (flag_w),
        .evt_active (evt_w),
        .alert_pol  (alert_pol),
        .alert_pin  (alert_pin)
    );

    assign slot_flag = flag_w;

endmodule

// File: rtl/limit_alert_ctrl_chk.sv
`timescale 1ns/1ps
// Property checker for limit_alert_ctrl, attached by bind below.
// Relates the top-level ports across clock edges.
module limit_alert_ctrl_chk #(
    parameter int NUM_CH   = 4,
    parameter int NUM_SLOT = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic [NUM_CH-1:0]   res_valid,
    input logic                latch_en,
    input logic                alert_pol,
    input logic                cnv_mask,
    input logic                eovf_mask,
    input logic                cnv_done,
    input logic [NUM_CH-1:0]   eovf,
    input logic [NUM_CH-1:0]   ch_en,
    input logic                flags_rd,
    input logic                alert_pin,
    input logic [NUM_SLOT-1:0] slot_flag,
    input logic                ready_flag
);
    // R8: latched flags hold without a strobe or a read
    a_r8_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid == '0 && !flags_rd && latch_en) |=> $stable(slot_flag));

    // R9: conversion event raises the ready flag
    a_r9_ready_set: assert property (@(posedge clk) disable iff (!rst_n)
        cnv_done |=> ready_flag);

    // R9: a read without a new event clears the ready flag
    a_r9_ready_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_rd && !cnv_done) |=> !ready_flag);

    // R9: a routed ready flag drives the pin active
    a_r9_ready_alert: assert property (@(posedge clk) disable iff (!rst_n)
        (cnv_mask && ready_flag) |=> (alert_pin == $past(alert_pol)));

    // R10: routed overflow of an enabled channel drives the pin active
    a_r10_ovf_alert: assert property (@(posedge clk) disable iff (!rst_n)
        (eovf_mask && (|(eovf & ch_en))) |=> (alert_pin == $past(alert_pol)));

    // R11: no cause at all leaves the pin at its idle level
    a_r11_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_flag == '0 && !(cnv_mask && ready_flag) && !(eovf_mask && (|(eovf & ch_en))))
        |=> (alert_pin != $past(alert_pol)));

endmodule

bind limit_alert_ctrl limit_alert_ctrl_chk #(
    .NUM_CH   (NUM_CH),
    .NUM_SLOT (NUM_SLOT)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .res_valid  (res_valid),
    .latch_en   (latch_en),
    .alert_pol  (alert_pol),
    .cnv_mask   (cnv_mask),
    .eovf_mask  (eovf_mask),
    .cnv_done   (cnv_done),
    .eovf       (eovf),
    .ch_en      (ch_en),
    .flags_rd   (flags_rd),
    .alert_pin  (alert_pin),
    .slot_flag  (slot_flag),
    .ready_flag (ready_flag)
);

// File: tb/sim_limit_alert_ctrl.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks queue expected port values stamped with a
// cycle number; a monitor on the falling edge pops and compares them.
module sim_limit_alert_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  res_valid = '0;
    logic [15:0] sh [4];
    logic [15:0] bu [4];
    logic [15:0] pw [4];
    logic [1:0]  sc_ch [4];
    logic [2:0]  sc_kd [4];
    logic [15:0] sc_lm [4];
    logic        latch_en = 1'b0, alert_pol = 1'b0, cnv_mask = 1'b0, eovf_mask = 1'b0;
    logic        cnv_done = 1'b0, flags_rd = 1'b0;
    logic [3:0]  eovf = '0, ch_en = 4'hF;
    logic        alert_pin, ready_flag;
    logic [3:0]  slot_flag;

    limit_alert_ctrl u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .res_valid  (res_valid),
        .shunt_res  ({sh[3], sh[2], sh[1], sh[0]}),
        .bus_res    ({bu[3], bu[2], bu[1], bu[0]}),
        .pwr_res    ({pw[3], pw[2], pw[1], pw[0]}),
        .slot_chan  ({sc_ch[3], sc_ch[2], sc_ch[1], sc_ch[0]}),
        .slot_kind  ({sc_kd[3], sc_kd[2], sc_kd[1], sc_kd[0]}),
        .slot_limit ({sc_lm[3], sc_lm[2], sc_lm[1], sc_lm[0]}),
        .latch_en   (latch_en),
        .alert_pol  (alert_pol),
        .cnv_mask   (cnv_mask),
        .eovf_mask  (eovf_mask),
        .cnv_done   (cnv_done),
        .eovf       (eovf),
        .ch_en      (ch_en),
        .flags_rd   (flags_rd),
        .alert_pin  (alert_pin),
        .slot_flag  (slot_flag),
        .ready_flag (ready_flag)
    );

    always #2.5 clk = ~clk;

    typedef struct {
        int    cyc;
        string req;
        int    sig;   // 0 slot_flag, 1 ready_flag, 2 alert_pin
        int    exp;
    } item_t;

    item_t sb[$];
    int    cyc = 0;
    int    n_chk = 0;
    int    n_fail = 0;
    bit    done = 1'b0;
    item_t it;
    int    act;

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: compare every item due in this cycle.
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].cyc <= cyc) begin
            it = sb.pop_front();
            case (it.sig)
                0:       act = int'(slot_flag);
                1:       act = int'(ready_flag);
                default: act = int'(alert_pin);
            endcase
            n_chk++;
            if (act != it.exp || it.cyc != cyc) begin
                n_fail++;
                $display("FAIL %s sig%0d cycle %0d: actual=%0h expected=%0h",
                         it.req, it.sig, cyc, act, it.exp);
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic expect_v(int at, string req, int sig, int v);
        item_t e;
        e.cyc = at; e.req = req; e.sig = sig; e.exp = v;
        sb.push_back(e);
    endtask

    // Strobe one channel; expect slot flags one edge later, the pin two edges later.
    task automatic pulse_ch(int c, string req, int f_exp, int a_exp);
        int sc;
        sc = cyc;
        res_valid[c] = 1'b1;
        expect_v(sc + 1, req, 0, f_exp);
        expect_v(sc + 2, req, 2, a_exp);
        tick();
        res_valid = '0;
        tick();
    endtask

    task automatic read_flags(string req, int f_exp, int r_exp, int a_exp);
        int sc;
        sc = cyc;
        flags_rd = 1'b1;
        expect_v(sc + 1, req, 0, f_exp);
        expect_v(sc + 1, req, 1, r_exp);
        expect_v(sc + 2, req, 2, a_exp);
        tick();
        flags_rd = 1'b0;
        tick();
    endtask

    task automatic cnv_pulse(string req, int r_exp, int a_exp);
        int sc;
        sc = cyc;
        cnv_done = 1'b1;
        expect_v(sc + 1, req, 1, r_exp);
        expect_v(sc + 2, req, 2, a_exp);
        tick();
        cnv_done = 1'b0;
        tick();
    endtask

    // Level-driven causes reach the pin one edge later.
    task automatic lvl(string req, int a_exp);
        int sc;
        sc = cyc;
        expect_v(sc + 1, req, 2, a_exp);
        tick();
        tick();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        for (int i = 0; i < 4; i++) begin
            sh[i] = '0; bu[i] = '0; pw[i] = '0;
            sc_ch[i] = '0; sc_kd[i] = '0; sc_lm[i] = '0;
        end
        tick(); tick(); tick();
        rst_n = 1'b1;
        // R1: reset state
        expect_v(cyc, "R1", 0, 0);
        expect_v(cyc, "R1", 1, 0);
        expect_v(cyc, "R1", 2, 1);
        tick();

        // R3: signed shunt over; R11 pin still idle one edge after the strobe
        sc_ch[0] = 2'd0; sc_kd[0] = 3'b001; sc_lm[0] = 16'h0100; sh[0] = 16'h0200;
        expect_v(cyc + 1, "R11", 2, 1);
        pulse_ch(0, "R3", 4'b0001, 0);
        sh[0] = 16'h0100;
        pulse_ch(0, "R3", 4'b0000, 1);             // equality, R7 tracking
        sc_kd[0] = 3'b010; sc_lm[0] = 16'hFF00; sh[0] = 16'h8000;
        pulse_ch(0, "R3", 4'b0001, 0);             // signed under
        sh[0] = 16'h7FFF;
        pulse_ch(0, "R3", 4'b0000, 1);             // positive is not under a negative

        // R2 / R5: slot 1 watches channel 2 power
        sc_ch[1] = 2'd2; sc_kd[1] = 3'b101; sc_lm[1] = 16'h7000;
        pw[0] = 16'h9000; pw[2] = 16'h9000;
        pulse_ch(0, "R2", 4'b0000, 1);
        pulse_ch(2, "R5", 4'b0010, 0);
        pw[2] = 16'h7000;
        pulse_ch(2, "R5", 4'b0000, 1);

        // R4: bus, 15-bit unsigned
        sc_ch[2] = 2'd1; sc_kd[2] = 3'b011; sc_lm[2] = 16'h8005; bu[1] = 16'h0006;
        pulse_ch(1, "R4", 4'b0100, 0);
        sc_kd[2] = 3'b100; bu[1] = 16'h0004;
        pulse_ch(1, "R4", 4'b0100, 0);
        bu[1] = 16'h0005;
        pulse_ch(1, "R4", 4'b0000, 1);
        sc_kd[2] = 3'b011; sc_lm[2] = 16'h0005; bu[1] = 16'h8004;
        pulse_ch(1, "R4", 4'b0000, 1);

        // R6: inert kind codes
        sc_ch[3] = 2'd3; sc_lm[3] = 16'h0000;
        sh[3] = 16'h7FFF; bu[3] = 16'h7FFF; pw[3] = 16'hFFFF;
        sc_kd[3] = 3'b000; pulse_ch(3, "R6", 4'b0000, 1);
        sc_kd[3] = 3'b110; pulse_ch(3, "R6", 4'b0000, 1);
        sc_kd[3] = 3'b111; pulse_ch(3, "R6", 4'b0000, 1);

        // R7: slot 3 maps to flag bit 3 while watching channel 0
        sc_ch[3] = 2'd0; sc_kd[3] = 3'b001; sh[0] = 16'h0001;
        pulse_ch(0, "R7", 4'b1000, 0);
        sh[0] = 16'h0000;
        pulse_ch(0, "R7", 4'b0000, 1);

        // R8: latched behaviour
        latch_en = 1'b1; tick();
        sh[0] = 16'h0005;
        pulse_ch(0, "R8", 4'b1000, 0);
        sh[0] = 16'h0000;
        pulse_ch(0, "R8", 4'b1000, 0);             // fault gone, not yet read
        read_flags("R8", 4'b0000, 0, 1);
        sh[0] = 16'h0005;
        pulse_ch(0, "R8", 4'b1000, 0);
        read_flags("R8", 4'b1000, 0, 0);           // read while fault persists
        sh[0] = 16'h0000;
        pulse_ch(0, "R8", 4'b1000, 0);
        read_flags("R8", 4'b0000, 0, 1);
        latch_en = 1'b0; tick();

        // R9: ready flag and its routing
        cnv_pulse("R9", 1, 1);                     // masked: pin idle
        read_flags("R9", 4'b0000, 0, 1);
        cnv_mask = 1'b1; tick();
        cnv_pulse("R9", 1, 0);
        read_flags("R9", 4'b0000, 0, 1);
        begin
            int sc;
            sc = cyc;
            cnv_done = 1'b1; flags_rd = 1'b1;      // set wins over clear
            expect_v(sc + 1, "R9", 1, 1);
            expect_v(sc + 2, "R9", 2, 0);
            tick();
            cnv_done = 1'b0; flags_rd = 1'b0;
            tick();
        end
        read_flags("R9", 4'b0000, 0, 1);
        cnv_mask = 1'b0; tick();

        // R10: energy overflow routing
        eovf = 4'b0001;
        lvl("R10", 1);
        eovf_mask = 1'b1;
        lvl("R10", 0);
        ch_en = 4'b1110;
        lvl("R10", 1);
        eovf = 4'b0100;
        lvl("R10", 0);

        // R11: polarity
        alert_pol = 1'b1;
        lvl("R11", 1);
        eovf = 4'b0000;
        lvl("R11", 0);
        alert_pol = 1'b0;
        lvl("R11", 1);

        tick(); tick(); tick();
        finish_run();
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #1000000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            finish_run();
        end
    end

endmodule